// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache placed between a processor request port and a slower main-memory port. It keeps 1024 lines of four 32-bit words, each line tagged and carrying a valid and a dirty flag. Each 32-bit byte address is split into a line-offset, an index that picks the line, and a tag compared against the stored one. Word reads and writes that hit are served from the cache alone.

On a miss the controller first writes the old line back to memory if it is valid and dirty, then reads the whole new line, and finally replays the request against the refilled line. Writes that miss therefore allocate the line before the word is merged in. The processor waits with a one-cycle completion strobe. Every memory exchange moves a complete 128-bit line through a request/acknowledge handshake of any length.

Top module: `dm_wb_cache`

## Requirements
- R1: Address bits [3:0] are the byte offset within a line (bits [3:2] pick the word, word 0 in line bits [31:0]), bits [13:4] the line index and bits [31:14] the tag; two addresses with the same index and different tags replace each other.
- R2: After reset `cpu_ready` and `mem_valid` are low and every line is invalid, so the first access to any index issues a memory line read.
- R3: A read that hits returns the addressed word and starts no memory transaction.
- R4: A write that hits changes only the cached word, starts no memory transaction, and marks the line dirty.
- R5: A read that misses on a clean or invalid line issues one memory read (`mem_write` low) at the line-aligned address and then returns the selected word of the fetched line.
- R6: A write that misses fetches the line first and then merges the word, leaving the other three words as fetched.
- R7: A miss on a valid dirty line first issues a memory write (`mem_write` high) of the whole stored line at the address built from the stored tag, the index and a zero offset, and only after it completes issues the line read.
- R8: A miss on a valid clean line issues no memory write.
- R9: `cpu_ready` is high for exactly one cycle per request and never while a memory transaction is open.
- R10: Once `mem_valid` is raised, it and `mem_addr`, `mem_write`, `mem_wdata` stay unchanged until `mem_ready` is seen high; `mem_valid` is low in the cycle after that.
- R11: Every memory address has its four low bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion strobe |
| mem_valid | output | 1 | Memory request open |
| mem_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written back |
| mem_rdata | input | 128 | Line fetched, valid with `mem_ready` |
| mem_ready | input | 1 | Memory acknowledge, one cycle |

## Verification
The assertions watch the two handshakes on every cycle: the single-cycle completion strobe, its exclusion while memory is busy, the stability of an open memory request, its drop after acknowledge and line alignment of every memory address. Whether a hit really avoids memory, whether the dirty flag is honoured, which tag forms the write-back address, the write-back-before-fetch order and the merging of a store into a fetched line only show through the bench's directed scenarios, which compare returned words and memory traffic against a reference memory model.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COMPARE = 2'd1,
    ST_WRBACK  = 2'd2,
    ST_FILL    = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_sp_ram.sv
module cache_sp_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] rd
);
  logic [WIDTH-1:0] mem [DEPTH];

  // write-first single port: a written word is visible on rd next cycle
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= we ? wd : mem[addr];
  end
endmodule

// File: rtl/cache_line_flags.sv
module cache_line_flags #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] idx,
  input  logic          fill,
  input  logic          mark_dirty,
  output logic          vld_o,
  output logic          dirty_o
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (fill) begin
      vld_q[idx]   <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  assign vld_o   = vld_q[idx];
  assign dirty_o = dirty_q[idx];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 1024,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int BSEL_W = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wd,
  input  logic [TAG_W-1:0]  tag_rd,
  output logic              data_we,
  output logic [LINE_W-1:0] data_wd,
  input  logic [LINE_W-1:0] data_rd,
  input  logic              line_vld,
  input  logic              line_dirty,
  output logic              flag_fill,
  output logic              flag_dirty
);
  cache_state_e state_q;

  logic [ADDR_W-1:0] req_addr_q;
  logic              req_write_q;
  logic [WORD_W-1:0] req_wdata_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              hit;
  logic              fill_done;
  logic [LINE_W-1:0] merged;
  logic              unused_bits;

  assign req_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr_q[OFF_W +: IDX_W];
  assign req_wsel = req_addr_q[BSEL_W +: WSEL_W];
  assign unused_bits = ^req_addr_q[BSEL_W-1:0];

  assign ram_idx   = (state_q == ST_IDLE) ? cpu_addr[OFF_W +: IDX_W] : req_idx;
  assign hit       = (state_q == ST_COMPARE) && line_vld && (tag_rd == req_tag);
  assign fill_done = (state_q == ST_FILL) && mem_valid && mem_ready;

  always_comb begin
    merged = data_rd;
    merged[req_wsel*WORD_W +: WORD_W] = req_wdata_q;
  end

  assign tag_we     = fill_done;
  assign tag_wd     = req_tag;
  assign data_we    = fill_done || (hit && req_write_q);
  assign data_wd    = fill_done ? mem_rdata : merged;
  assign flag_fill  = fill_done;
  assign flag_dirty = hit && req_write_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      req_write_q <= 1'b0;
      req_wdata_q <= '0;
      cpu_rdata   <= '0;
      cpu_ready   <= 1'b0;
      mem_valid   <= 1'b0;
      mem_write   <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_valid) begin
            req_addr_q  <= cpu_addr;
            req_write_q <= cpu_write;
            req_wdata_q <= cpu_wdata;
            state_q     <= ST_COMPARE;
          end
        end
        ST_COMPARE: begin
          if (hit) begin
            if (!req_write_q) cpu_rdata <= data_rd[req_wsel*WORD_W +: WORD_W];
            cpu_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (line_vld && line_dirty) begin
            mem_valid <= 1'b1;
            mem_write <= 1'b1;
            mem_addr  <= {tag_rd, req_idx, {OFF_W{1'b0}}};
            mem_wdata <= data_rd;
            state_q   <= ST_WRBACK;
          end else begin
            mem_valid <= 1'b1;
            mem_write <= 1'b0;
            mem_addr  <= {req_tag, req_idx, {OFF_W{1'b0}}};
            state_q   <= ST_FILL;
          end
        end
        ST_WRBACK: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_valid && mem_ready) begin
            mem_valid <= 1'b0;
            state_q   <= ST_COMPARE;
          end else if (!mem_valid) begin
            mem_valid <= 1'b1;
            mem_write <= 1'b0;
            mem_addr  <= {req_tag, req_idx, {OFF_W{1'b0}}};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  a_r9_no_ready_mem_busy: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !cpu_ready);

  a_r10_request_held: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  a_r10_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> !mem_valid);

  a_r11_line_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 1024,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  logic [IDX_W-1:0]  ram_idx;
  logic              tag_we;
  logic [TAG_W-1:0]  tag_wd;
  logic [TAG_W-1:0]  tag_rd;
  logic              data_we;
  logic [LINE_W-1:0] data_wd;
  logic [LINE_W-1:0] data_rd;
  logic              line_vld;
  logic              line_dirty;
  logic              flag_fill;
  logic              flag_dirty;

  cache_sp_ram #(.DEPTH(LINES), .WIDTH(TAG_W)) i_tag_ram (
    .clk  (clk),
    .addr (ram_idx),
    .we   (tag_we),
    .wd   (tag_wd),
    .rd   (tag_rd)
  );

  cache_sp_ram #(.DEPTH(LINES), .WIDTH(LINE_W)) i_data_ram (
    .clk  (clk),
    .addr (ram_idx),
    .we   (data_we),
    .wd   (data_wd),
    .rd   (data_rd)
  );

  cache_line_flags #(.DEPTH(LINES)) i_flags (
    .clk        (clk),
    .rst        (rst),
    .idx        (ram_idx),
    .fill       (flag_fill),
    .mark_dirty (flag_dirty),
    .vld_o      (line_vld),
    .dirty_o    (line_dirty)
  );

  cache_ctrl #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS),
    .LINES      (LINES)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .cpu_ready  (cpu_ready),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ready  (mem_ready),
    .ram_idx    (ram_idx),
    .tag_we     (tag_we),
    .tag_wd     (tag_wd),
    .tag_rd     (tag_rd),
    .data_we    (data_we),
    .data_wd    (data_wd),
    .data_rd    (data_rd),
    .line_vld   (line_vld),
    .line_dirty (line_dirty),
    .flag_fill  (flag_fill),
    .flag_dirty (flag_dirty)
  );

  a_r2_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!cpu_ready && !mem_valid));
endmodule

// File: tb/test_dm_wb_cache.sv
`timescale 1ns/1ps
module test_dm_wb_cache;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0;
  logic         cpu_write = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid;
  logic         mem_write;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  dm_wb_cache i_dm_wb_cache (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // reference main memory: lines written back, else a computed pattern
  logic [127:0] wmem [logic [31:0]];
  int lat = 1;
  int n_rd = 0, n_wr = 0, seq = 0;
  int last_rd_seq = 0, last_wr_seq = 0;
  logic [31:0]  last_rd_addr = '0, last_wr_addr = '0;
  logic [127:0] last_wr_data = '0;

  function automatic logic [127:0] line_of(logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return {a ^ 32'hA5A50003, a ^ 32'h3C3C0002, a ^ 32'h0F0F0001, a ^ 32'h5A5A0000};
  endfunction

  function automatic logic [31:0] word_of(logic [31:0] a);
    logic [127:0] l;
    l = line_of({a[31:4], 4'h0});
    return l[a[3:2]*32 +: 32];
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_valid && !mem_ready) begin
        logic [31:0]  a;
        logic         w;
        logic [127:0] d;
        a = mem_addr; w = mem_write; d = mem_wdata;
        seq++;
        if (w) begin n_wr++; last_wr_addr = a; last_wr_data = d; last_wr_seq = seq; end
        else   begin n_rd++; last_rd_addr = a; last_rd_seq = seq; end
        repeat (lat) @(negedge clk);
        if (w) wmem[a] = d;
        else   mem_rdata = line_of(a);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
      end
    end
  end

  // port monitors
  int v_block = 0, v_hold = 0, v_align = 0;
  logic         p_open = 1'b0, p_ready = 1'b0, p_write = 1'b0;
  logic [31:0]  p_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cpu_ready && (mem_valid || p_ready)) v_block++;
      if (mem_valid && mem_addr[3:0] != 4'h0) v_align++;
      if (p_open && (!mem_valid || mem_addr != p_addr || mem_write != p_write)) v_hold++;
      p_open  = mem_valid && !mem_ready;
      p_addr  = mem_addr;
      p_write = mem_write;
      p_ready = cpu_ready;
    end
  end

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rdata);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    rdata = cpu_rdata;
    cpu_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2", "cpu_ready after reset", 128'(cpu_ready), 128'(0));
    chk("R2", "mem_valid after reset", 128'(mem_valid), 128'(0));
  endtask

  task automatic t_cold_read();
    logic [31:0] r;
    int r0 = n_rd, w0 = n_wr;
    lat = 0;
    access(1'b0, 32'h0000_1234, 32'h0, r);
    chk("R5", "cold read word", 128'(r), 128'(word_of(32'h0000_1234)));
    chk("R2", "cold access fetch count", 128'(n_rd - r0), 128'(1));
    chk("R5", "no write on cold miss", 128'(n_wr - w0), 128'(0));
    chk("R11", "fetch address", 128'(last_rd_addr), 128'(32'h0000_1230));
  endtask

  task automatic t_read_hits();
    logic [31:0] r;
    int s0 = seq;
    access(1'b0, 32'h0000_1238, 32'h0, r);
    chk("R3", "hit word 2", 128'(r), 128'(word_of(32'h0000_1238)));
    access(1'b0, 32'h0000_123C, 32'h0, r);
    chk("R3", "hit word 3", 128'(r), 128'(word_of(32'h0000_123C)));
    chk("R3", "no memory traffic on hits", 128'(seq - s0), 128'(0));
  endtask

  task automatic t_write_hit();
    logic [31:0] r;
    int s0 = seq;
    access(1'b1, 32'h0000_1230, 32'hDEAD_BEEF, r);
    access(1'b0, 32'h0000_1230, 32'h0, r);
    chk("R4", "written word read back", 128'(r), 128'(32'hDEAD_BEEF));
    chk("R4", "no memory traffic on write hit", 128'(seq - s0), 128'(0));
  endtask

  task automatic t_dirty_evict();
    logic [31:0]  r;
    logic [127:0] exp_line;
    int w0 = n_wr;
    exp_line = line_of(32'h0000_1230);
    exp_line[31:0] = 32'hDEAD_BEEF;
    lat = 3;
    access(1'b0, 32'h0000_5230, 32'h0, r);
    chk("R7", "write-back count", 128'(n_wr - w0), 128'(1));
    chk("R7", "write-back address", 128'(last_wr_addr), 128'(32'h0000_1230));
    chk("R7", "write-back line", last_wr_data, exp_line);
    chk("R7", "write-back before fetch", 128'(last_wr_seq < last_rd_seq), 128'(1));
    chk("R1", "conflicting tag word", 128'(r), 128'(word_of(32'h0000_5230)));
  endtask

  task automatic t_clean_evict();
    logic [31:0] r;
    int w0 = n_wr, r0 = n_rd;
    lat = 5;
    access(1'b0, 32'h0000_1234, 32'h0, r);
    chk("R8", "no write-back of clean line", 128'(n_wr - w0), 128'(0));
    chk("R8", "one fetch", 128'(n_rd - r0), 128'(1));
    chk("R8", "refetched word 1", 128'(r), 128'(word_of(32'h0000_1234)));
    access(1'b0, 32'h0000_1230, 32'h0, r);
    chk("R7", "written-back word survives", 128'(r), 128'(32'hDEAD_BEEF));
  endtask

  task automatic t_write_miss();
    logic [31:0] r;
    int w0 = n_wr, r0 = n_rd, s0;
    lat = 2;
    access(1'b1, 32'h0000_0044, 32'h1234_5678, r);
    chk("R6", "allocate fetch", 128'(n_rd - r0), 128'(1));
    chk("R6", "no write-back on invalid line", 128'(n_wr - w0), 128'(0));
    chk("R11", "allocate address", 128'(last_rd_addr), 128'(32'h0000_0040));
    s0 = seq;
    access(1'b0, 32'h0000_0048, 32'h0, r);
    chk("R6", "neighbour word kept", 128'(r), 128'(word_of(32'h0000_0048)));
    access(1'b0, 32'h0000_0044, 32'h0, r);
    chk("R6", "merged word", 128'(r), 128'(32'h1234_5678));
    chk("R6", "later reads hit", 128'(seq - s0), 128'(0));
  endtask

  task automatic t_write_miss_dirty();
    logic [31:0]  r;
    logic [127:0] exp_line;
    exp_line = line_of(32'h0000_0040);
    exp_line[63:32] = 32'h1234_5678;
    lat = 1;
    access(1'b1, 32'h0000_4044, 32'hCAFE_F00D, r);
    chk("R7", "dirty write-miss victim address", 128'(last_wr_addr), 128'(32'h0000_0040));
    chk("R7", "dirty write-miss victim line", last_wr_data, exp_line);
    chk("R6", "write-miss fetch address", 128'(last_rd_addr), 128'(32'h0000_4040));
    access(1'b0, 32'h0000_4044, 32'h0, r);
    chk("R6", "merged after eviction", 128'(r), 128'(32'hCAFE_F00D));
  endtask

  task automatic t_index_edges();
    logic [31:0] r;
    int w0 = n_wr;
    lat = 0;
    access(1'b0, 32'h0000_3FFC, 32'h0, r);
    chk("R1", "last index word", 128'(r), 128'(word_of(32'h0000_3FFC)));
    chk("R1", "last index fetch address", 128'(last_rd_addr), 128'(32'h0000_3FF0));
    access(1'b0, 32'hFFFF_FFF8, 32'h0, r);
    chk("R1", "all-ones tag word", 128'(r), 128'(word_of(32'hFFFF_FFF8)));
    chk("R1", "all-ones tag fetch address", 128'(last_rd_addr), 128'(32'hFFFF_FFF0));
    chk("R8", "clean conflict no write", 128'(n_wr - w0), 128'(0));
  endtask

  task automatic t_monitors();
    chk("R9", "ready strobe violations", 128'(v_block), 128'(0));
    chk("R10", "request hold violations", 128'(v_hold), 128'(0));
    chk("R11", "alignment violations", 128'(v_align), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_read();
    t_read_hits();
    t_write_hit();
    t_dirty_evict();
    t_clean_evict();
    t_write_miss();
    t_write_miss_dirty();
    t_index_edges();
    repeat (4) @(negedge clk);
    t_monitors();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule